// File: doc/BRIEF.md
# Dual-Channel Memory Fill Engine

The block clears or paints regions of memory with a repeating pixel value. It has two channels, and each has its own register set: a start address, an end address, a pattern and a control word. Software programs a channel and then sets its trigger bit. The engine then walks the address range and writes the pattern as whole 32-bit words with byte enables on a single write port. A write goes out every clock cycle. When the channel is done, the engine raises that channel's completion interrupt.

The pixel size is 16, 24 or 32 bits. A 16-bit or 24-bit pattern does not divide evenly into words, so the engine tracks the pixel phase of each byte lane as it advances. Lanes outside the covered bytes stay disabled. Only one channel drives the port at a time, and a fill always finishes before the other channel's fill can begin. The engine copies a channel's settings when the fill begins, so register writes made while the fill runs do not change it.

Top module: `memfill_dual`

## Requirements
- R1: Writing 1 to control bit 0 (trigger) of an idle channel starts a fill. The trigger reads 1 from that write until the operation completes. A channel triggered while the other channel is filling waits until that fill has issued all its writes and completed.
- R2: Register select `cfg_addr[2]` chooses the channel and `cfg_addr[1:0]` chooses the register: 0 start, 1 end, 2 pattern, 3 control. Control bits are 0 trigger, 1 finished, 2 select-24, 3 select-32. Every register reads back its current value on `cfg_rdata` for the address on `cfg_raddr`.
- R3: The pixel size is 3 bytes when select-24 is set, whatever select-32 holds. Otherwise it is 4 bytes when select-32 is set, and 2 bytes when neither is set.
- R4: The byte at address start+o receives pattern byte (o mod size), where pattern byte i is bits [8i+7:8i]. In 24-bit mode this puts red (bits 7:0) at pixel offset 0, green (15:8) at offset 1 and blue (23:16) at offset 2.
- R5: Pixels begin at start+k*size for every k with start+k*size < end. Each pixel is written in full. Writes go out one per cycle, at word-aligned ascending addresses, and enable exactly the covered byte lanes.
- R6: In the cycle after a fill's last write, the trigger reads 0, finished reads 1, and `irq[ch]` is high for exactly one cycle.
- R7: If the start register holds 0 when the fill begins, no write and no interrupt occur. The trigger still clears and finished still sets.
- R8: If start is nonzero and end <= start, no write occurs. The operation still completes with finished set and a one-cycle interrupt.
- R9: Writing 0 to the finished bit clears it. Writing 1 to it never sets it.
- R10: While a channel's trigger reads 1, writes to its control register are ignored. Changing its start, end or pattern registers during a fill does not alter that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Write register select |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 3 | Read register select |
| cfg_rdata | output | 32 | Read data for `cfg_raddr` |
| mem_we | output | 1 | Memory write valid |
| mem_addr | output | AW | Word-aligned write address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data, lane i in bits [8i+7:8i] |
| irq | output | 2 | Per-channel completion pulse |

## Verification
The address-step property assumes the range of a fill does not wrap past the top of the address space. The stimulus keeps every range in low memory, well away from the top. The checks also take for granted that software changes a running channel only through the register port, and that the memory port accepts one write in every cycle. The bench drives no back-pressure and writes to a busy channel only to test R10.

// File: rtl/memfill_dual.sv
module memfill_dual #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic [2:0]    cfg_raddr,
  output logic [31:0]   cfg_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  output logic [1:0]    irq
);

  typedef enum logic {IDLE, RUN} st_t;

  function automatic logic [1:0] mod_e(input logic [3:0] v, input logic [2:0] e);
    logic [3:0] r;
    if (e == 3'd2)      r = {3'b0, v[0]};
    else if (e == 3'd4) r = {2'b0, v[1:0]};
    else if (v >= 4'd12) r = v - 4'd12;
    else if (v >= 4'd9)  r = v - 4'd9;
    else if (v >= 4'd6)  r = v - 4'd6;
    else if (v >= 4'd3)  r = v - 4'd3;
    else                 r = v;
    return r[1:0];
  endfunction

  function automatic logic [2:0] elem_size(input logic s24, input logic s32);
    return s24 ? 3'd3 : (s32 ? 3'd4 : 3'd2);
  endfunction

  st_t            st;
  logic [AW-1:0]  r_start [2];
  logic [AW-1:0]  r_end   [2];
  logic [31:0]    r_pat   [2];
  logic [1:0]     trig, fin, s24, s32;
  logic [1:0]     irq_q;

  logic           act;
  logic [AW-3:0]  word;
  logic [1:0]     ph0, lo;
  logic           first;
  logic [2:0]     esz;
  logic [AW-1:0]  wend;
  logic [31:0]    wpat;

  logic           sel;
  logic [2:0]     sel_e;
  logic [1:0]     ph0n;
  logic [AW-1:0]  nxt_el;
  logic           last;
  logic [3:0]     be;
  logic           wc;

  assign sel    = ~trig[0];
  assign sel_e  = elem_size(s24[sel], s32[sel]);
  assign wc     = cfg_addr[2];
  assign mem_we = (st == RUN);
  assign mem_addr = {word, 2'b00};
  assign mem_be = be & {4{mem_we}};
  assign irq    = irq_q;

  assign ph0n   = mod_e({2'b00, ph0} + 4'd4, esz);
  assign nxt_el = {word + 1'b1, 2'b00} - AW'(ph0n);
  assign last   = !(nxt_el < wend);

  always_comb begin
    be = '0;
    mem_wdata = '0;
    for (int l = 0; l < 4; l++) begin
      logic [1:0]    ph;
      logic [AW-1:0] el;
      ph = mod_e({2'b00, ph0} + 4'(l), esz);
      el = {word, 2'(l)} - AW'(ph);
      if ((!first || 2'(l) >= lo) && el < wend) be[l] = 1'b1;
      mem_wdata[8*l +: 8] = wpat[{ph, 3'b000} +: 8];
    end
  end

  always_comb begin
    case (cfg_raddr[1:0])
      2'd0:    cfg_rdata = 32'(r_start[cfg_raddr[2]]);
      2'd1:    cfg_rdata = 32'(r_end[cfg_raddr[2]]);
      2'd2:    cfg_rdata = r_pat[cfg_raddr[2]];
      default: cfg_rdata = {28'b0, s32[cfg_raddr[2]], s24[cfg_raddr[2]],
                            fin[cfg_raddr[2]], trig[cfg_raddr[2]]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      r_start[0] <= '0; r_start[1] <= '0;
      r_end[0]   <= '0; r_end[1]   <= '0;
      r_pat[0]   <= '0; r_pat[1]   <= '0;
      trig <= '0; fin <= '0; s24 <= '0; s32 <= '0;
      irq_q <= '0;
      act <= 1'b0; word <= '0; ph0 <= '0; lo <= '0; first <= 1'b0;
      esz <= 3'd2; wend <= '0; wpat <= '0;
    end else begin
      irq_q <= '0;
      if (cfg_we) begin
        case (cfg_addr[1:0])
          2'd0: r_start[wc] <= cfg_wdata[AW-1:0];
          2'd1: r_end[wc]   <= cfg_wdata[AW-1:0];
          2'd2: r_pat[wc]   <= cfg_wdata;
          default:
            if (!trig[wc]) begin
              trig[wc] <= cfg_wdata[0];
              fin[wc]  <= fin[wc] & cfg_wdata[1];
              s24[wc]  <= cfg_wdata[2];
              s32[wc]  <= cfg_wdata[3];
            end
        endcase
      end
      case (st)
        IDLE:
          if (trig != 2'b00) begin
            if (r_start[sel] == '0) begin
              trig[sel] <= 1'b0;
              fin[sel]  <= 1'b1;
            end else if (r_end[sel] <= r_start[sel]) begin
              trig[sel]  <= 1'b0;
              fin[sel]   <= 1'b1;
              irq_q[sel] <= 1'b1;
            end else begin
              st    <= RUN;
              act   <= sel;
              word  <= r_start[sel][AW-1:2];
              lo    <= r_start[sel][1:0];
              first <= 1'b1;
              esz   <= sel_e;
              ph0   <= mod_e(4'd12 - {2'b00, r_start[sel][1:0]}, sel_e);
              wend  <= r_end[sel];
              wpat  <= r_pat[sel];
            end
          end
        default: begin
          first <= 1'b0;
          word  <= word + 1'b1;
          ph0   <= ph0n;
          if (last) begin
            st         <= IDLE;
            trig[act]  <= 1'b0;
            fin[act]   <= 1'b1;
            irq_q[act] <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/memfill_dual_chk.sv
module memfill_dual_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic [1:0]    irq,
  input logic [1:0]    trig,
  input logic [1:0]    fin
);

  AST_LANES_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_be != 4'b0000); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) + AW'(4)); // R5

  AST_WRITE_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> trig != 2'b00); // R1

  AST_IRQ0_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |=> !irq[0]); // R6

  AST_IRQ1_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |=> !irq[1]); // R6

  AST_IRQ0_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> fin[0] && !trig[0]); // R6

  AST_IRQ1_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |-> fin[1] && !trig[1]); // R6

  AST_FIN0_FROM_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin[0]) |-> $past(trig[0])); // R9

  AST_FIN1_FROM_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin[1]) |-> $past(trig[1])); // R9

endmodule

bind memfill_dual memfill_dual_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_be(mem_be), .irq(irq), .trig(trig), .fin(fin)
);

// File: tb/sim_memfill_dual.sv
`timescale 1ns/1ps
module sim_memfill_dual;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0, cfg_raddr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [1:0]  irq;

  memfill_dual #(.AW(32)) u0 (.*);

  always #2 clk = ~clk;

  typedef struct {
    bit          is_irq;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [1:0]  mask;
    bit          adj;
    string       tag;
  } item_t;

  item_t expq[$];
  item_t it;
  int nchk = 0, nfail = 0;
  bit prev_we = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lanemask(logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    if (mem_we) begin
      if (expq.size() == 0) chk(0, "R5 unexpected write", mem_addr, 32'hffffffff);
      else begin
        it = expq.pop_front();
        chk(!it.is_irq, {it.tag, " write instead of irq"}, mem_addr, 32'(it.mask));
        chk(mem_addr == it.addr, {it.tag, " addr"}, mem_addr, it.addr);
        chk(mem_be == it.be, {it.tag, " byte enables"}, 32'(mem_be), 32'(it.be));
        chk((mem_wdata & lanemask(it.be)) == (it.data & lanemask(it.be)),
            {it.tag, " data"}, mem_wdata & lanemask(it.be), it.data & lanemask(it.be));
      end
    end
    if (irq != 2'b00) begin
      if (expq.size() == 0) chk(0, "R7 unexpected irq", 32'(irq), 0);
      else begin
        it = expq.pop_front();
        chk(it.is_irq && irq == it.mask, {it.tag, " irq"}, 32'(irq), 32'(it.mask));
        if (it.adj) chk(prev_we, {it.tag, " R6 irq one cycle after last write"}, 32'(prev_we), 1);
      end
    end
    prev_we = mem_we;
  end

  task automatic push_fill(int ch, longint s, longint e, logic [31:0] pat, int esz, string tag);
    item_t x;
    longint cw;
    bit have;
    if (s == 0) return;
    have = 0; cw = 0;
    x.is_irq = 0; x.be = 0; x.data = 0; x.mask = 0; x.adj = 0; x.tag = tag;
    for (longint k = 0; s + k * esz < e; k++)
      for (int b = 0; b < esz; b++) begin
        longint a;
        a = s + k * esz + b;
        if (have && (a & ~64'd3) != cw) begin
          x.addr = cw[31:0]; expq.push_back(x); x.be = 0; x.data = 0;
        end
        cw = a & ~64'd3; have = 1;
        x.be[a[1:0]] = 1'b1;
        x.data[8*a[1:0] +: 8] = pat[8*b +: 8];
      end
    if (have) begin x.addr = cw[31:0]; expq.push_back(x); end
    x.is_irq = 1; x.mask = (ch == 0) ? 2'b01 : 2'b10; x.adj = have;
    expq.push_back(x);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    cfg_raddr = a; #1; d = cfg_rdata;
  endtask

  task automatic wait_idle(int ch);
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(3'(ch * 4 + 3), v);
      if (!v[0]) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic fill(int ch, logic [31:0] s, logic [31:0] e, logic [31:0] pat,
                      logic [1:0] mode, string tag);
    logic [31:0] v;
    int esz;
    esz = mode[0] ? 3 : (mode[1] ? 4 : 2);
    wr(3'(ch * 4 + 0), s);
    wr(3'(ch * 4 + 1), e);
    wr(3'(ch * 4 + 2), pat);
    push_fill(ch, longint'(s), longint'(e), pat, esz, tag);
    wr(3'(ch * 4 + 3), {28'b0, mode, 2'b01});
    rd(3'(ch * 4 + 3), v);
    chk(v[0] == 1'b1, {tag, " R1 trigger reads 1 while busy"}, v, 32'h1);
    wait_idle(ch);
    rd(3'(ch * 4 + 3), v);
    chk(v[1:0] == 2'b10, {tag, " R6 status after completion"}, 32'(v[1:0]), 2);
  endtask

  initial begin
    #400000;
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R2 reset register value", v, 0);
    end
    chk(mem_we == 0 && irq == 0, "R6 reset outputs idle", {31'b0, mem_we}, 0);

    fill(0, 32'h100, 32'h110, 32'h0000BEEF, 2'b00, "R5 16-bit aligned");
    fill(0, 32'h202, 32'h209, 32'h00001234, 2'b00, "R4 16-bit unaligned");
    fill(1, 32'h301, 32'h309, 32'hCAFEF00D, 2'b10, "R4 32-bit unaligned");
    fill(1, 32'h400, 32'h40B, 32'h00332211, 2'b01, "R4 24-bit rgb");
    fill(0, 32'h501, 32'h505, 32'h00C0B0A0, 2'b11, "R3 24 over 32");
    fill(0, 32'h603, 32'h60A, 32'h00665544, 2'b01, "R5 24-bit odd start");
    fill(1, 32'h000, 32'h040, 32'h12345678, 2'b10, "R7 zero start");
    fill(0, 32'h700, 32'h700, 32'h0000AAAA, 2'b00, "R8 empty range");
    fill(1, 32'h710, 32'h708, 32'h0000AAAA, 2'b10, "R8 reversed range");

    rd(3'd0, v); chk(v == 32'h700, "R2 start readback", v, 32'h700);
    rd(3'd6, v); chk(v == 32'h0000AAAA, "R2 pattern readback", v, 32'h0000AAAA);

    wr(3'd3, 32'h0);
    rd(3'd3, v); chk(v[1] == 0, "R9 finished cleared by 0", v, 0);
    wr(3'd3, 32'h2);
    rd(3'd3, v); chk(v[1] == 0, "R9 writing 1 does not set finished", v, 0);

    wr(3'd4, 32'h800); wr(3'd5, 32'h840); wr(3'd6, 32'h11223344);
    push_fill(1, 64'h800, 64'h840, 32'h11223344, 4, "R10 snapshot ch1");
    wr(3'd0, 32'h900); wr(3'd1, 32'h904); wr(3'd2, 32'h0000A5A5);
    push_fill(0, 64'h900, 64'h904, 32'h0000A5A5, 2, "R1 ch0 waits");
    wr(3'd3, 32'h0);
    wr(3'd7, 32'h9);
    wr(3'd6, 32'hDEAD0000);
    wr(3'd4, 32'h0);
    wr(3'd7, 32'h5);
    wr(3'd3, 32'h1);
    wait_idle(1);
    wait_idle(0);
    rd(3'd7, v); chk(v == 32'hA, "R10 busy control write ignored", v, 32'hA);
    rd(3'd6, v); chk(v == 32'hDEAD0000, "R2 pattern written during run", v, 32'hDEAD0000);
    rd(3'd3, v); chk(v[1:0] == 2'b10, "R1 ch0 completed after ch1", v, 2);

    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R5 all expected events seen", 32'(expq.size()), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule